// File: doc/BRIEF.md
# DRAM Access Strobe Sequencer

This block produces the address and strobe timing for a bank of dynamic RAM. A three-bit mode input selects how the strobes are made. In the two automatic access modes, one falling edge of the incoming row strobe runs the whole access. The selected bank's row strobe goes low, and the row address is held for a programmable number of clock cycles. The address mux then switches to the column, and after a column setup interval the column strobe is asserted. The slow-hold mode waits longer before the column switch than the fast-hold mode.

The same pins also support modes in which the outside system controls all timing. In external access mode, the decoded bank strobe, the column strobe and the mux select each follow a system input, registered by one cycle. The all-bank mode drives all four row strobes together. The refresh modes put a refresh row counter on the address lines, drive all row strobes, and report the end of a refresh pass on a status pin. A set-end-of-count mode loads the wrap point of that counter. The write enable is registered on its own path and is never decided by the block.

Address inputs pass through latches. These latches are transparent while no strobe is active and hold from the cycle an access starts.

Top module: `dram_access_seq`

## Requirements
- R1: While `rst_n` is low, all of `ras_n_out`, `cas_n_out` and `we_n_out` are high, `rf_eoc` is 0, and `addr_out` is 0. Reset also clears the refresh counter to 0 and sets the end count to all ones.
- R2: While no row strobe is active, `addr_out` shows `row_addr` as sampled at the previous clock edge. From the edge that starts an access until one cycle after the strobe ends, the latched row, column and bank values do not change.
- R3: In the auto modes (`mode_sel` 101 and 110), the first edge that samples `ras_in_n` low after it was high drives `ras_n_out[bank_sel]` low. The other row strobe bits stay high.
- R4: `addr_out` switches from the latched row to the latched column a fixed time after that edge. In mode 110 this is HOLD_FAST cycles (default 1). In mode 101 it is HOLD_SLOW cycles (default 3).
- R5: `cas_n_out` goes low COL_SETUP cycles (default 1) after the column switch, and stays low while `ras_in_n` stays low.
- R6: In an auto mode, the first edge that samples `ras_in_n` high during an access releases the access. At that edge the row and column strobes go high and `addr_out` returns to the row, also when the access was still in its hold interval.
- R7: In mode 100, the strobe of the latched bank follows `ras_in_n`, `cas_n_out` follows `ext_cas_n`, and the mux follows `ext_col_sel` (1 selects the column). Each follows with one cycle of delay.
- R8: In mode 011, all four row strobes follow `ras_in_n` with one cycle of delay, and `cas_n_out` follows `ext_cas_n`.
- R9: In every mode, `we_n_out` equals `we_in_n` as sampled at the previous edge.
- R10: In the auto modes, `ext_cas_n` and `ext_col_sel` have no effect on the outputs.
- R11: In mode 111, a falling edge of `ras_in_n` loads `row_addr` as the refresh end count. No row or column strobe is asserted in this mode.
- R12: In modes 000, 001 and 010, `addr_out` carries the refresh counter and all row strobes follow `ras_in_n`, while `cas_n_out` stays high. The counter advances on each rising edge of `ras_in_n`. When it advances from the end count, it wraps to 0 and `rf_eoc` is 1 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 3 | Operating mode |
| ras_in_n | input | 1 | Row strobe request, active low |
| row_addr | input | AW | Row address |
| col_addr | input | AW | Column address |
| bank_sel | input | BANK_W | Bank select |
| we_in_n | input | 1 | Write enable from the system, active low |
| ext_cas_n | input | 1 | Column strobe in external modes, active low |
| ext_col_sel | input | 1 | Mux select in external modes, 1 selects the column |
| addr_out | output | AW | Multiplexed DRAM address |
| ras_n_out | output | 2**BANK_W | Per-bank row strobes, active low |
| cas_n_out | output | 1 | Column strobe, active low |
| we_n_out | output | 1 | Buffered write enable, active low |
| rf_eoc | output | 1 | One-cycle pulse when the refresh counter wraps |

## Verification
The bench counts the exact edge of the row strobe, the column switch and the column strobe, in both the fast and the slow mode. A design with an off-by-one hold counter would move the mux or the column strobe one cycle early or late. The bench also releases the strobe while the access is still in its hold interval, so a sequencer that does not abort at once would leave a row strobe low or later raise the column strobe. It changes `row_addr` during an access and checks that the address held on the outputs stays unchanged, which catches latches that remain transparent. Finally, it sets a small end count and counts refresh strobes, so a counter that wraps one step early or late, or that never pulses the status pin, is caught.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    MD_RFSH_EXT   = 3'b000,
    MD_RFSH_FORCE = 3'b001,
    MD_RFSH_BURST = 3'b010,
    MD_ALL_BANK   = 3'b011,
    MD_EXT_ACC    = 3'b100,
    MD_AUTO_SLOW  = 3'b101,
    MD_AUTO_FAST  = 3'b110,
    MD_SET_EOC    = 3'b111
  } mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_HOLD   = 2'd1,
    SQ_SETUP  = 2'd2,
    SQ_STROBE = 2'd3
  } seq_state_e;

  function automatic logic is_auto_mode(input logic [2:0] m);
    return (m == MD_AUTO_SLOW) || (m == MD_AUTO_FAST);
  endfunction

  function automatic logic is_rfsh_mode(input logic [2:0] m);
    return (m == MD_RFSH_EXT) || (m == MD_RFSH_FORCE) || (m == MD_RFSH_BURST);
  endfunction

  // modes whose row strobe comes straight from the system request
  function automatic logic is_ext_strobe_mode(input logic [2:0] m);
    return is_rfsh_mode(m) || (m == MD_ALL_BANK) || (m == MD_EXT_ACC);
  endfunction

  // modes where the system also drives column strobe and mux
  function automatic logic is_ext_cas_mode(input logic [2:0] m);
    return (m == MD_ALL_BANK) || (m == MD_EXT_ACC);
  endfunction

  function automatic logic drives_all_banks(input logic [2:0] m);
    return is_rfsh_mode(m) || (m == MD_ALL_BANK);
  endfunction

  // row hold length in cycles for a given auto mode
  function automatic int unsigned row_hold_len(input logic slow,
                                               input int unsigned hs,
                                               input int unsigned hf);
    return slow ? hs : hf;
  endfunction

endpackage

// File: rtl/dram_auto_seq.sv
module dram_auto_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned HOLD_SLOW = 3,
  parameter int unsigned HOLD_FAST = 1,
  parameter int unsigned COL_SETUP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic slow_sel,
  input  logic strobe_fall,
  input  logic ras_in_n,
  output logic ras_on,
  output logic col_sel,
  output logic cas_on
);

  localparam int unsigned MAXLEN = (HOLD_SLOW > HOLD_FAST) ?
                                   ((HOLD_SLOW > COL_SETUP) ? HOLD_SLOW : COL_SETUP) :
                                   ((HOLD_FAST > COL_SETUP) ? HOLD_FAST : COL_SETUP);
  localparam int unsigned CW = $clog2(MAXLEN + 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          release_req;
  logic          cnt_last;

  initial begin
    assert (HOLD_SLOW >= 1 && HOLD_FAST >= 1 && COL_SETUP >= 1)
      else $error("sequencer intervals must be at least one cycle");
  end

  assign release_req = (state_q != SQ_IDLE) && ras_in_n;
  assign cnt_last    = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else if (!auto_en || release_req) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (strobe_fall) begin
            state_q <= SQ_HOLD;
            cnt_q   <= CW'(row_hold_len(slow_sel, HOLD_SLOW, HOLD_FAST));
          end
        end
        SQ_HOLD: begin
          if (cnt_last) begin
            state_q <= SQ_SETUP;
            cnt_q   <= CW'(COL_SETUP);
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        SQ_SETUP: begin
          if (cnt_last) begin
            state_q <= SQ_STROBE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: state_q <= SQ_STROBE;
      endcase
    end
  end

  assign ras_on  = (state_q != SQ_IDLE);
  assign col_sel = (state_q == SQ_SETUP) || (state_q == SQ_STROBE);
  assign cas_on  = (state_q == SQ_STROBE);

  // R3: a row strobe only starts from a sampled falling request
  a_r3_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_on) |-> $past(strobe_fall));

  // R5: column strobe never rises without column address already on the mux
  a_r5_cas_after_col: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_on) |-> $past(col_sel));

  // R6: a released request clears every strobe at the next edge
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_on && ras_in_n) |=> (!ras_on && !cas_on && !col_sel));

endmodule

// File: rtl/dram_addr_latch.sv
module dram_addr_latch #(
  parameter int unsigned AW     = 9,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [AW-1:0]     row_in,
  input  logic [AW-1:0]     col_in,
  input  logic [BANK_W-1:0] bank_in,
  input  logic              col_sel,
  input  logic              rfsh_sel,
  input  logic [AW-1:0]     rfsh_row,
  output logic [AW-1:0]     addr_out,
  output logic [BANK_W-1:0] bank_out
);

  logic [AW-1:0]     row_q;
  logic [AW-1:0]     col_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      bank_q <= '0;
    end else if (!hold) begin
      row_q  <= row_in;
      col_q  <= col_in;
      bank_q <= bank_in;
    end
  end

  always_comb begin
    if (rfsh_sel)     addr_out = rfsh_row;
    else if (col_sel) addr_out = col_q;
    else              addr_out = row_q;
  end

  assign bank_out = bank_q;

  // R2: latches are frozen after any cycle in which an access was active
  a_r2_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> ($stable(row_q) && $stable(col_q) && $stable(bank_q)));

endmodule

// File: rtl/dram_rfsh_ctr.sv
module dram_rfsh_ctr #(
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load_end,
  input  logic [AW-1:0] end_val,
  output logic [AW-1:0] rfsh_row,
  output logic          wrap_pulse
);

  logic [AW-1:0] cnt_q;
  logic [AW-1:0] end_q;
  logic          at_end;

  assign at_end = (cnt_q == end_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      end_q      <= '1;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= 1'b0;
      if (load_end) end_q <= end_val;
      if (step) begin
        if (at_end) begin
          cnt_q      <= '0;
          wrap_pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_q + AW'(1);
        end
      end
    end
  end

  assign rfsh_row = cnt_q;

  // R12: the end-of-count pulse lasts one cycle and follows a counting step
  a_r12_wrap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> ($past(step) && (rfsh_row == '0)));

  a_r12_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse);

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned AW        = 9,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned HOLD_SLOW = 3,
  parameter int unsigned HOLD_FAST = 1,
  parameter int unsigned COL_SETUP = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               mode_sel,
  input  logic                     ras_in_n,
  input  logic [AW-1:0]            row_addr,
  input  logic [AW-1:0]            col_addr,
  input  logic [BANK_W-1:0]        bank_sel,
  input  logic                     we_in_n,
  input  logic                     ext_cas_n,
  input  logic                     ext_col_sel,
  output logic [AW-1:0]            addr_out,
  output logic [(1<<BANK_W)-1:0]   ras_n_out,
  output logic                     cas_n_out,
  output logic                     we_n_out,
  output logic                     rf_eoc
);

  localparam int unsigned NBANK = 1 << BANK_W;

  // named events for assertions and debug
  logic              req_prev_hi;
  logic              strobe_fall;
  logic              strobe_rise;
  logic              auto_en;
  logic              seq_ras_on;
  logic              seq_col_sel;
  logic              seq_cas_on;
  logic              ext_ras_q;
  logic              ext_cas_q;
  logic              ext_col_q;
  logic              all_bank_q;
  logic              rfsh_q;
  logic              we_q;
  logic              latch_hold;
  logic              mux_col;
  logic [AW-1:0]     rfsh_row;
  logic [BANK_W-1:0] bank_q;
  logic [NBANK-1:0]  bank_hit;
  logic [NBANK-1:0]  ras_active;

  assign strobe_fall = req_prev_hi && !ras_in_n;
  assign strobe_rise = !req_prev_hi && ras_in_n;
  assign auto_en     = is_auto_mode(mode_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_hi <= 1'b1;
      ext_ras_q   <= 1'b0;
      ext_cas_q   <= 1'b0;
      ext_col_q   <= 1'b0;
      all_bank_q  <= 1'b0;
      rfsh_q      <= 1'b0;
      we_q        <= 1'b1;
    end else begin
      req_prev_hi <= ras_in_n;
      ext_ras_q   <= is_ext_strobe_mode(mode_sel) && !ras_in_n;
      ext_cas_q   <= is_ext_cas_mode(mode_sel) && !ext_cas_n;
      ext_col_q   <= is_ext_cas_mode(mode_sel) && ext_col_sel;
      all_bank_q  <= drives_all_banks(mode_sel);
      rfsh_q      <= is_rfsh_mode(mode_sel);
      we_q        <= we_in_n;
    end
  end

  dram_auto_seq #(
    .HOLD_SLOW (HOLD_SLOW),
    .HOLD_FAST (HOLD_FAST),
    .COL_SETUP (COL_SETUP)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_en     (auto_en),
    .slow_sel    (mode_sel == MD_AUTO_SLOW),
    .strobe_fall (strobe_fall),
    .ras_in_n    (ras_in_n),
    .ras_on      (seq_ras_on),
    .col_sel     (seq_col_sel),
    .cas_on      (seq_cas_on)
  );

  assign latch_hold = seq_ras_on || ext_ras_q;
  assign mux_col    = seq_col_sel || ext_col_q;

  dram_addr_latch #(
    .AW     (AW),
    .BANK_W (BANK_W)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (latch_hold),
    .row_in   (row_addr),
    .col_in   (col_addr),
    .bank_in  (bank_sel),
    .col_sel  (mux_col),
    .rfsh_sel (rfsh_q),
    .rfsh_row (rfsh_row),
    .addr_out (addr_out),
    .bank_out (bank_q)
  );

  dram_rfsh_ctr #(
    .AW (AW)
  ) u_rfsh (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (is_rfsh_mode(mode_sel) && strobe_rise),
    .load_end   ((mode_sel == MD_SET_EOC) && strobe_fall),
    .end_val    (row_addr),
    .rfsh_row   (rfsh_row),
    .wrap_pulse (rf_eoc)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_hit[b]   = (bank_q == BANK_W'(b));
    assign ras_active[b] = (seq_ras_on && bank_hit[b]) ||
                           (ext_ras_q && (all_bank_q || bank_hit[b]));
    assign ras_n_out[b]  = !ras_active[b];
  end

  assign cas_n_out = !(seq_cas_on || ext_cas_q);
  assign we_n_out  = we_q;

  // R3: an auto access strobes exactly one bank
  a_r3_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    seq_ras_on |-> $onehot(ras_active));

  // R10: in the auto modes the external column strobe and mux stay out
  a_r10_auto_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    $past(auto_en) |-> (!ext_cas_q && !ext_col_q));

  // R12: refresh never asserts the column strobe
  a_r12_no_cas_in_rfsh: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_q |-> cas_n_out);

  // R8: all-bank external strobe drives every row strobe together
  a_r8_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ras_q && all_bank_q) |-> (ras_n_out == '0));

endmodule

// File: tb/dram_access_seq_bench.sv
module dram_access_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 39;

  typedef struct packed {
    logic [2:0] md;
    logic       rs;
    logic [8:0] row;
    logic [8:0] col;
    logic [1:0] bk;
    logic       we;
    logic       xc;
    logic       xm;
    logic [3:0] eras;
    logic       ecas;
    logic [8:0] eaddr;
    logic       erf;
    logic [3:0] req;
  } vec_t;

  // fields: mode, ras_in_n, row, col, bank, we, ext_cas_n, ext_col_sel,
  //         expected ras_n_out, cas_n_out, addr_out, rf_eoc, requirement number
  localparam vec_t VEC [NV] = '{
    // fast auto, bank 2 (R2 R3 R4 R5 R6 R9)
    '{3'b110,1'b1,9'h055,9'h0AA,2'd2,1'b1,1'b1,1'b0,4'hF,1'b1,9'h055,1'b0,4'd2},
    '{3'b110,1'b0,9'h055,9'h0AA,2'd2,1'b0,1'b1,1'b0,4'hB,1'b1,9'h055,1'b0,4'd3},
    '{3'b110,1'b0,9'h1FF,9'h0AA,2'd2,1'b0,1'b1,1'b0,4'hB,1'b1,9'h0AA,1'b0,4'd4},
    '{3'b110,1'b0,9'h1FF,9'h0AA,2'd2,1'b0,1'b1,1'b0,4'hB,1'b0,9'h0AA,1'b0,4'd5},
    '{3'b110,1'b0,9'h1FF,9'h0AA,2'd2,1'b1,1'b1,1'b0,4'hB,1'b0,9'h0AA,1'b0,4'd9},
    '{3'b110,1'b1,9'h1FF,9'h0AA,2'd2,1'b1,1'b1,1'b0,4'hF,1'b1,9'h055,1'b0,4'd6},
    '{3'b110,1'b1,9'h1FF,9'h0AA,2'd2,1'b1,1'b1,1'b0,4'hF,1'b1,9'h1FF,1'b0,4'd2},
    // slow auto, bank 1 (R4 R5)
    '{3'b101,1'b1,9'h123,9'h0F0,2'd1,1'b1,1'b1,1'b0,4'hF,1'b1,9'h123,1'b0,4'd2},
    '{3'b101,1'b0,9'h123,9'h0F0,2'd1,1'b1,1'b1,1'b0,4'hD,1'b1,9'h123,1'b0,4'd3},
    '{3'b101,1'b0,9'h123,9'h0F0,2'd1,1'b1,1'b1,1'b0,4'hD,1'b1,9'h123,1'b0,4'd4},
    '{3'b101,1'b0,9'h123,9'h0F0,2'd1,1'b1,1'b1,1'b0,4'hD,1'b1,9'h123,1'b0,4'd4},
    '{3'b101,1'b0,9'h123,9'h0F0,2'd1,1'b1,1'b1,1'b0,4'hD,1'b1,9'h0F0,1'b0,4'd4},
    '{3'b101,1'b0,9'h123,9'h0F0,2'd1,1'b1,1'b1,1'b0,4'hD,1'b0,9'h0F0,1'b0,4'd5},
    '{3'b101,1'b1,9'h123,9'h0F0,2'd1,1'b1,1'b1,1'b0,4'hF,1'b1,9'h123,1'b0,4'd6},
    // abort during the hold interval, bank 3 (R6)
    '{3'b101,1'b0,9'h123,9'h0F0,2'd3,1'b1,1'b1,1'b0,4'h7,1'b1,9'h123,1'b0,4'd3},
    '{3'b101,1'b1,9'h123,9'h0F0,2'd3,1'b1,1'b1,1'b0,4'hF,1'b1,9'h123,1'b0,4'd6},
    // external access, bank 0 (R7)
    '{3'b100,1'b1,9'h0C3,9'h13C,2'd0,1'b1,1'b1,1'b0,4'hF,1'b1,9'h0C3,1'b0,4'd7},
    '{3'b100,1'b0,9'h0C3,9'h13C,2'd0,1'b1,1'b1,1'b0,4'hE,1'b1,9'h0C3,1'b0,4'd7},
    '{3'b100,1'b0,9'h0C3,9'h13C,2'd0,1'b1,1'b1,1'b1,4'hE,1'b1,9'h13C,1'b0,4'd7},
    '{3'b100,1'b0,9'h0C3,9'h13C,2'd0,1'b1,1'b0,1'b1,4'hE,1'b0,9'h13C,1'b0,4'd7},
    '{3'b100,1'b0,9'h0C3,9'h13C,2'd0,1'b1,1'b0,1'b0,4'hE,1'b0,9'h0C3,1'b0,4'd7},
    '{3'b100,1'b1,9'h0C3,9'h13C,2'd0,1'b1,1'b1,1'b0,4'hF,1'b1,9'h0C3,1'b0,4'd7},
    // all-bank external (R8)
    '{3'b011,1'b0,9'h0C3,9'h13C,2'd0,1'b1,1'b1,1'b0,4'h0,1'b1,9'h0C3,1'b0,4'd8},
    '{3'b011,1'b0,9'h0C3,9'h13C,2'd0,1'b1,1'b0,1'b0,4'h0,1'b0,9'h0C3,1'b0,4'd8},
    '{3'b011,1'b1,9'h0C3,9'h13C,2'd0,1'b1,1'b1,1'b0,4'hF,1'b1,9'h0C3,1'b0,4'd8},
    // auto mode ignores the external strobe and mux inputs (R10)
    '{3'b110,1'b1,9'h0C3,9'h13C,2'd0,1'b1,1'b0,1'b1,4'hF,1'b1,9'h0C3,1'b0,4'd10},
    // set end of count to 2 (R11)
    '{3'b111,1'b1,9'h002,9'h13C,2'd0,1'b1,1'b1,1'b0,4'hF,1'b1,9'h002,1'b0,4'd11},
    '{3'b111,1'b0,9'h002,9'h13C,2'd0,1'b1,1'b0,1'b0,4'hF,1'b1,9'h002,1'b0,4'd11},
    '{3'b111,1'b1,9'h002,9'h13C,2'd0,1'b1,1'b1,1'b0,4'hF,1'b1,9'h002,1'b0,4'd11},
    // refresh pass with wrap at 2 (R12)
    '{3'b000,1'b1,9'h002,9'h13C,2'd0,1'b1,1'b1,1'b0,4'hF,1'b1,9'h000,1'b0,4'd12},
    '{3'b000,1'b0,9'h002,9'h13C,2'd0,1'b1,1'b1,1'b0,4'h0,1'b1,9'h000,1'b0,4'd12},
    '{3'b000,1'b1,9'h002,9'h13C,2'd0,1'b1,1'b1,1'b0,4'hF,1'b1,9'h001,1'b0,4'd12},
    '{3'b000,1'b0,9'h002,9'h13C,2'd0,1'b1,1'b1,1'b0,4'h0,1'b1,9'h001,1'b0,4'd12},
    '{3'b000,1'b1,9'h002,9'h13C,2'd0,1'b1,1'b1,1'b0,4'hF,1'b1,9'h002,1'b0,4'd12},
    '{3'b000,1'b0,9'h002,9'h13C,2'd0,1'b1,1'b0,1'b0,4'h0,1'b1,9'h002,1'b0,4'd12},
    '{3'b000,1'b1,9'h002,9'h13C,2'd0,1'b1,1'b1,1'b0,4'hF,1'b1,9'h000,1'b1,4'd12},
    '{3'b000,1'b1,9'h002,9'h13C,2'd0,1'b1,1'b1,1'b0,4'hF,1'b1,9'h000,1'b0,4'd12},
    '{3'b001,1'b0,9'h002,9'h13C,2'd0,1'b1,1'b1,1'b0,4'h0,1'b1,9'h000,1'b0,4'd12},
    '{3'b001,1'b1,9'h002,9'h13C,2'd0,1'b1,1'b1,1'b0,4'hF,1'b1,9'h001,1'b0,4'd12}
  };

  logic       clk;
  logic       rst_n;
  logic [2:0] mode_sel;
  logic       ras_in_n;
  logic [8:0] row_addr;
  logic [8:0] col_addr;
  logic [1:0] bank_sel;
  logic       we_in_n;
  logic       ext_cas_n;
  logic       ext_col_sel;
  logic [8:0] addr_out;
  logic [3:0] ras_n_out;
  logic       cas_n_out;
  logic       we_n_out;
  logic       rf_eoc;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  dram_access_seq u_dram_access_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .ras_in_n    (ras_in_n),
    .row_addr    (row_addr),
    .col_addr    (col_addr),
    .bank_sel    (bank_sel),
    .we_in_n     (we_in_n),
    .ext_cas_n   (ext_cas_n),
    .ext_col_sel (ext_col_sel),
    .addr_out    (addr_out),
    .ras_n_out   (ras_n_out),
    .cas_n_out   (cas_n_out),
    .we_n_out    (we_n_out),
    .rf_eoc      (rf_eoc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_outs(input string tag, input logic [3:0] eras,
                            input logic ecas, input logic [8:0] eaddr,
                            input logic ewe, input logic erf);
    check(tag, "ras_n_out", 16'(ras_n_out), 16'(eras));
    check(tag, "cas_n_out", 16'(cas_n_out), 16'(ecas));
    check(tag, "addr_out",  16'(addr_out),  16'(eaddr));
    check(tag, "we_n_out",  16'(we_n_out),  16'(ewe));
    check(tag, "rf_eoc",    16'(rf_eoc),    16'(erf));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n       = 1'b0;
    mode_sel    = 3'b110;
    ras_in_n    = 1'b1;
    row_addr    = 9'h1AB;
    col_addr    = 9'h0CD;
    bank_sel    = 2'd0;
    we_in_n     = 1'b0;
    ext_cas_n   = 1'b0;
    ext_col_sel = 1'b1;
    tick();
    tick();
    // R1: outputs idle under reset despite active inputs
    check_outs("R1", 4'hF, 1'b1, 9'h000, 1'b1, 1'b0);
    ext_cas_n   = 1'b1;
    ext_col_sel = 1'b0;
    we_in_n     = 1'b1;
    rst_n       = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      mode_sel    = VEC[i].md;
      ras_in_n    = VEC[i].rs;
      row_addr    = VEC[i].row;
      col_addr    = VEC[i].col;
      bank_sel    = VEC[i].bk;
      we_in_n     = VEC[i].we;
      ext_cas_n   = VEC[i].xc;
      ext_col_sel = VEC[i].xm;
      tick();
      check($sformatf("R%0d row%0d", VEC[i].req, i), "ras_n_out",
            16'(ras_n_out), 16'(VEC[i].eras));
      check($sformatf("R%0d row%0d", VEC[i].req, i), "cas_n_out",
            16'(cas_n_out), 16'(VEC[i].ecas));
      check($sformatf("R%0d row%0d", VEC[i].req, i), "addr_out",
            16'(addr_out), 16'(VEC[i].eaddr));
      // R9: write enable follows its input by one edge
      check($sformatf("R9 row%0d", i), "we_n_out",
            16'(we_n_out), 16'(VEC[i].we));
      check($sformatf("R%0d row%0d", VEC[i].req, i), "rf_eoc",
            16'(rf_eoc), 16'(VEC[i].erf));
    end

    // R1: reset in the middle of an access clears strobes and counters
    mode_sel = 3'b110;
    row_addr = 9'h066;
    bank_sel = 2'd0;
    ras_in_n = 1'b1;
    tick();
    ras_in_n = 1'b0;
    tick();
    tick();
    tick();
    check("R5 pre-reset", "cas_n_out", 16'(cas_n_out), 16'(1'b0));
    rst_n = 1'b0;
    #1;
    check_outs("R1 async", 4'hF, 1'b1, 9'h000, 1'b1, 1'b0);
    tick();
    mode_sel = 3'b000;
    ras_in_n = 1'b1;
    rst_n    = 1'b1;
    tick();
    check("R1 counter", "addr_out", 16'(addr_out), 16'h0000);

    // R12: after reset the end count is all ones, so a few steps do not wrap
    for (int k = 1; k <= 3; k++) begin
      ras_in_n = 1'b0;
      tick();
      ras_in_n = 1'b1;
      tick();
      check($sformatf("R12 step%0d", k), "addr_out", 16'(addr_out), 16'(k));
      check($sformatf("R12 step%0d", k), "rf_eoc", 16'(rf_eoc), 16'h0000);
    end

    // R10: ext_cas_n held low through an auto fast access changes nothing early
    mode_sel    = 3'b110;
    row_addr    = 9'h011;
    col_addr    = 9'h022;
    bank_sel    = 2'd3;
    ext_cas_n   = 1'b0;
    ext_col_sel = 1'b1;
    tick();
    ras_in_n = 1'b0;
    tick();
    check("R10 auto", "cas_n_out", 16'(cas_n_out), 16'h0001);
    check("R10 auto", "addr_out", 16'(addr_out), 16'h0011);
    check("R3 bank3", "ras_n_out", 16'(ras_n_out), 16'h0007);
    ras_in_n = 1'b1;
    tick();
    check("R6 early release", "ras_n_out", 16'(ras_n_out), 16'h000F);

    finish_run();
  end

endmodule